// File: doc/BRIEF.md
# Four-Channel Converter Serial-Frame Responder

This block is the digital side of a four-input, 10-bit sampling converter. It answers a host that drives a chip-select, a serial clock and a serial data line. The host clocks conversion slots of sixteen serial clocks each. In every slot the block asserts a track strobe and then a hold strobe. It latches a parallel result word at the hold point and shifts that word out, most significant bit first, behind four zero lead bits. The host shifts in a control byte during the same slot. Two bits of that byte choose which input the following slot converts.

All three serial inputs are brought onto a fast system clock through two-flop synchronizers, and serial clock edges are found by comparing successive synchronized samples. As a result, every output reacts three system clocks after the pin edge that caused it. The system clock must run at least eight times faster than the serial clock. The analog side (input multiplexer, sampling capacitor, comparator) lies outside the block. It sees the selected channel on `chan_o`, uses the track and hold strobes, and returns its word on `result_i`.

Top module: `adc_frame_resp`

## Requirements
- R1: While the synchronized chip-select is high, `dout_oe_o` is 0, `dout_o` is 0, `pwrdn_o` is 1 and both `track_o` and `hold_o` are 0. Serial clock edges in that state change nothing.
- R2: If the serial clock is low when chip-select falls, the chip-select fall counts as falling edge 1 of the first slot. If the serial clock is high, slot timing begins at the first real serial clock fall after chip-select falls.
- R3: Within a slot, `track_o` is high from falling edge 1 up to falling edge 4. `hold_o` is high from falling edge 4 up to falling edge 16.
- R4: `pwrdn_o` is high from falling edge 16 of a slot until falling edge 1 of the next slot. It is also high while chip-select is low and no falling edge has yet been seen.
- R5: `result_i` is sampled at the clock where falling edge 4 takes effect. Later changes to `result_i` do not alter the word sent in that slot.
- R6: After falling edges 1 to 4 `dout_o` is 0. After falling edges 5 to 14 it carries result bits 9 down to 0 in straight binary. After falling edges 15 and 16 it is 0.
- R7: The control byte is shifted in MSB first on rising edges 1 to 8 of each slot. Byte bits 4:3 select the channel: 00 gives 0, 01 gives 1, 10 gives 2, 11 gives 3. Bits 7:5 and 2:0 have no effect.
- R8: A channel captured in one slot drives `chan_o` from falling edge 1 of the next slot. The pending value survives chip-select high gaps. After reset `chan_o` is 0.
- R9: While chip-select stays low, slots follow one another back to back. The falling edge after rising edge 16 is falling edge 1 of the next slot.
- R10: Each output reacts to a pin change three system clocks after the pin is sampled. This covers two synchronizer stages and one edge-detect stage.
- R11: If chip-select rises in mid-slot, the block returns to the idle state of R1. A control byte that received fewer than eight rising edges leaves the pending channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip-select from host, active low, asynchronous |
| sclk_i | input | 1 | Serial clock from host, asynchronous |
| din_i | input | 1 | Serial control data from host |
| result_i | input | 10 | Conversion word from the analog side |
| dout_o | output | 1 | Serial result data |
| dout_oe_o | output | 1 | Output enable for the serial data pad |
| chan_o | output | 2 | Input channel selected for the current slot |
| track_o | output | 1 | Sampling (track) phase strobe |
| hold_o | output | 1 | Hold/convert phase strobe |
| pwrdn_o | output | 1 | Power-down indication |

## Verification
Two cases are hard to reach from the ports. The first is the one-slot lag of channel selection across chip-select gaps. The second is a control byte cut short by a chip-select rise. Both are covered by a sequence of frames whose control bytes differ. One frame starts with the serial clock parked low and another with it parked high. One frame is aborted after five rising edges. The channel seen in each slot is then compared with the byte of the slot before it. Result words are changed just after the hold point, so a late sample would show up in the received word.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;
  typedef enum logic [1:0] {
    PH_OFF   = 2'd0,
    PH_GAP   = 2'd1,
    PH_TRACK = 2'd2,
    PH_HOLD  = 2'd3
  } slot_phase_e;

  typedef struct packed {
    logic fall;
    logic rise;
  } sclk_evt_t;
endpackage

// File: rtl/adc_in_sync.sv
module adc_in_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= d_i;
    end
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= {stg_q[STAGES-2:0], d_i};
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adc_slot_seq.sv
module adc_slot_seq
  import adc_resp_pkg::*;
#(
  parameter int SLOT_LEN = 16,
  parameter int TRACK_CYC = 3,
  parameter int CNT_W = $clog2(SLOT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_s,
  input  logic             sclk_s,
  output sclk_evt_t        evt_o,
  output logic [CNT_W-1:0] fc_o,
  output logic [CNT_W-1:0] fc_nxt_o,
  output logic             act_o,
  output slot_phase_e      phase_o
);
  localparam logic [CNT_W-1:0] LAST_FALL = CNT_W'(SLOT_LEN);
  localparam logic [CNT_W-1:0] TRK_END   = CNT_W'(TRACK_CYC);

  logic             sclk_q, cs_q, act_q;
  logic [CNT_W-1:0] fc_q, fc_d;
  logic             cs_fell, fall_evt, rise_evt, fc_en;

  always_comb begin
    cs_fell  = cs_q & ~cs_s;
    fall_evt = ~cs_s & ~sclk_s & (sclk_q | cs_fell);
    rise_evt = ~cs_s & ~sclk_q & sclk_s & (fc_q != '0);
    fc_en    = cs_s | fall_evt;
    fc_d     = fc_q;
    if (cs_s)
      fc_d = '0;
    else if (fall_evt)
      fc_d = ((fc_q == '0) || (fc_q == LAST_FALL)) ? CNT_W'(1) : fc_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      act_q  <= 1'b0;
      fc_q   <= '0;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_s;
      act_q  <= ~cs_s;
      if (fc_en) fc_q <= fc_d;
    end
  end

  always_comb begin
    if (!act_q)
      phase_o = PH_OFF;
    else if ((fc_q == '0) || (fc_q == LAST_FALL))
      phase_o = PH_GAP;
    else if (fc_q <= TRK_END)
      phase_o = PH_TRACK;
    else
      phase_o = PH_HOLD;
  end

  assign evt_o    = '{fall: fall_evt, rise: rise_evt};
  assign fc_o     = fc_q;
  assign fc_nxt_o = fc_d;
  assign act_o    = act_q;
endmodule

// File: rtl/adc_ctrl_cap.sv
module adc_ctrl_cap
  import adc_resp_pkg::*;
#(
  parameter int CTRL_W = 8,
  parameter int ADDR_LSB = 3,
  parameter int ADDR_W = 2,
  parameter int CNT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sclk_evt_t         evt_i,
  input  logic [CNT_W-1:0]  fc_i,
  input  logic [CNT_W-1:0]  fc_nxt_i,
  input  logic              din_s,
  output logic [ADDR_W-1:0] chan_o
);
  localparam logic [CNT_W-1:0] CAP_END = CNT_W'(CTRL_W);

  logic [CTRL_W-1:0] sh_q, sh_d;
  logic [ADDR_W-1:0] pend_q, chan_q;
  logic              cap_en, byte_done, slot_start;

  always_comb begin
    cap_en     = evt_i.rise & (fc_i != '0) & (fc_i <= CAP_END);
    byte_done  = cap_en & (fc_i == CAP_END);
    slot_start = evt_i.fall & (fc_nxt_i == CNT_W'(1));
    sh_d       = {sh_q[CTRL_W-2:0], din_s};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pend_q <= '0;
      chan_q <= '0;
    end else begin
      if (cap_en)     sh_q   <= sh_d;
      if (byte_done)  pend_q <= sh_d[ADDR_LSB +: ADDR_W];
      if (slot_start) chan_q <= pend_q;
    end
  end

  assign chan_o = chan_q;
endmodule

// File: rtl/adc_result_tx.sv
module adc_result_tx
  import adc_resp_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int LEAD_ZEROS = 4,
  parameter int HOLD_AT = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sclk_evt_t        evt_i,
  input  logic [CNT_W-1:0] fc_i,
  input  logic [CNT_W-1:0] fc_nxt_i,
  input  logic             act_i,
  input  logic [RES_W-1:0] result_i,
  output logic             dout_o
);
  localparam int FIRST_BIT = LEAD_ZEROS + 1;
  localparam int LAST_BIT  = LEAD_ZEROS + RES_W;

  logic [RES_W-1:0] res_q, shifted;
  logic [CNT_W-1:0] idx;
  logic             grab, in_win;

  always_comb begin
    grab    = evt_i.fall & (fc_nxt_i == CNT_W'(HOLD_AT));
    in_win  = act_i & (fc_i >= CNT_W'(FIRST_BIT)) & (fc_i <= CNT_W'(LAST_BIT));
    idx     = CNT_W'(LAST_BIT) - fc_i;
    shifted = res_q >> idx;
    dout_o  = in_win & shifted[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (grab) res_q <= result_i;
  end
endmodule

// File: rtl/adc_frame_resp.sv
module adc_frame_resp
  import adc_resp_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int SLOT_LEN = 16,
  parameter int TRACK_CYC = 3,
  parameter int LEAD_ZEROS = 4,
  parameter int CTRL_W = 8,
  parameter int ADDR_LSB = 3,
  parameter int ADDR_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [ADDR_W-1:0] chan_o,
  output logic              track_o,
  output logic              hold_o,
  output logic              pwrdn_o
);
  localparam int CNT_W   = $clog2(SLOT_LEN + 1);
  localparam int HOLD_AT = TRACK_CYC + 1;

  logic [2:0]       pins_s;
  sclk_evt_t        evt;
  logic [CNT_W-1:0] fc, fc_nxt;
  logic             act;
  slot_phase_e      phase;

  adc_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i({cs_n_i, sclk_i, din_i}), .q_o(pins_s)
  );

  adc_slot_seq #(.SLOT_LEN(SLOT_LEN), .TRACK_CYC(TRACK_CYC), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .sclk_s(pins_s[1]),
    .evt_o(evt), .fc_o(fc), .fc_nxt_o(fc_nxt), .act_o(act), .phase_o(phase)
  );

  adc_ctrl_cap #(.CTRL_W(CTRL_W), .ADDR_LSB(ADDR_LSB), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .fc_i(fc), .fc_nxt_i(fc_nxt),
    .din_s(pins_s[0]), .chan_o(chan_o)
  );

  adc_result_tx #(.RES_W(RES_W), .LEAD_ZEROS(LEAD_ZEROS), .HOLD_AT(HOLD_AT), .CNT_W(CNT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .fc_i(fc), .fc_nxt_i(fc_nxt),
    .act_i(act), .result_i(result_i), .dout_o(dout_o)
  );

  assign dout_oe_o = act;
  assign track_o   = (phase == PH_TRACK);
  assign hold_o    = (phase == PH_HOLD);
  assign pwrdn_o   = (phase == PH_OFF) || (phase == PH_GAP);
endmodule

// File: rtl/adc_frame_resp_chk.sv
module adc_frame_resp_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dout_o,
  input logic              dout_oe_o,
  input logic [ADDR_W-1:0] chan_o,
  input logic              track_o,
  input logic              hold_o,
  input logic              pwrdn_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe_o |-> (pwrdn_o && !dout_o && !track_o && !hold_o)); // R1
  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({track_o, hold_o, pwrdn_o})); // R3
  AST_HOLD_AFTER_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_o) |-> $past(track_o)); // R3
  AST_TRACK_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track_o) |-> $past(pwrdn_o)); // R4
  AST_LEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    track_o |-> !dout_o); // R6
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    pwrdn_o |-> !dout_o); // R6
  AST_CHAN_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan_o) |-> $rose(track_o)); // R8
endmodule

bind adc_frame_resp adc_frame_resp_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .dout_o(dout_o), .dout_oe_o(dout_oe_o),
  .chan_o(chan_o), .track_o(track_o), .hold_o(hold_o), .pwrdn_o(pwrdn_o)
);

// File: tb/sim_adc_frame_resp.sv
`timescale 1ns/1ps
module sim_adc_frame_resp;
  localparam int H = 8;

  logic       clk, rst_n, cs_n, sclk, din;
  logic [9:0] result_i;
  logic       dout_o, dout_oe_o, track_o, hold_o, pwrdn_o;
  logic [1:0] chan_o;

  int nchk = 0, nerr = 0, cyc = 0;
  bit cmp_en = 0;
  int rxq[$];
  int chq[$];

  adc_frame_resp u0 (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .din_i(din),
    .result_i(result_i), .dout_o(dout_o), .dout_oe_o(dout_oe_o), .chan_o(chan_o),
    .track_o(track_o), .hold_o(hold_o), .pwrdn_o(pwrdn_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Behavioural reference: pins are seen three clocks late (R10)
  bit   hc[4], hs[4], hd[4];
  int   m_fc;
  bit   m_act;
  logic [7:0] m_byte;
  logic [1:0] m_pend, m_chan;
  logic [9:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin hc[i] = 1; hs[i] = 0; hd[i] = 0; end
      m_fc = 0; m_act = 0; m_byte = 0; m_pend = 0; m_chan = 0; m_res = 0;
    end else begin
      bit rise, fall;
      for (int i = 3; i > 0; i--) begin hc[i] = hc[i-1]; hs[i] = hs[i-1]; hd[i] = hd[i-1]; end
      hc[0] = cs_n; hs[0] = sclk; hd[0] = din;
      if (hc[2]) m_fc = 0;
      else begin
        rise = !hs[3] && hs[2] && (m_fc != 0);
        fall = !hs[2] && (hs[3] || hc[3]);
        if (rise && m_fc >= 1 && m_fc <= 8) begin
          m_byte = {m_byte[6:0], hd[2]};
          if (m_fc == 8) m_pend = m_byte[4:3];
        end
        if (fall) begin
          m_fc = (m_fc == 0 || m_fc == 16) ? 1 : m_fc + 1;
          if (m_fc == 1) m_chan = m_pend;
          if (m_fc == 4) m_res = result_i;
        end
      end
      m_act = !hc[2];
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R1 dout_oe_o vs model", int'(dout_oe_o), int'(m_act));
      chk("R3 track_o vs model", int'(track_o), int'(m_act && m_fc >= 1 && m_fc <= 3));
      chk("R3 hold_o vs model", int'(hold_o), int'(m_act && m_fc >= 4 && m_fc <= 15));
      chk("R4 pwrdn_o vs model", int'(pwrdn_o), int'(!m_act || m_fc == 0 || m_fc == 16));
      chk("R6 dout_o vs model", int'(dout_o),
          (m_act && m_fc >= 5 && m_fc <= 14) ? int'(m_res[14-m_fc]) : 0);
      chk("R8 chan_o vs model", int'(chan_o), int'(m_chan));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nchk++; nerr++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic do_frame(input int nconv, input logic [7:0] c0, input logic [7:0] c1,
                          input logic [9:0] v0, input bit hi_start, input int max_rises);
    int rises;
    bit stop;
    logic [9:0] w;
    logic [1:0] ch;
    rises = 0; stop = 0; w = 0; ch = 0;
    rxq.delete(); chq.delete();
    sclk = hi_start; wait_clk(H);
    result_i = v0;
    din = c0[7];
    cs_n = 1'b0;
    if (!hi_start) begin
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R10 track_o still low two clocks after CS fall", int'(track_o), 0);
      @(posedge clk); @(negedge clk);
      chk("R2 CS fall with SCLK low starts track", int'(track_o), 1);
      wait_clk(H - 3);
    end else begin
      wait_clk(H);
      chk("R2 no track before first SCLK fall", int'(track_o), 0);
      chk("R4 pwrdn_o while waiting for first fall", int'(pwrdn_o), 1);
    end
    for (int cv = 0; cv < nconv; cv++) begin
      logic [7:0] c;
      c = cv[0] ? c1 : c0;
      w = 0;
      for (int b = 0; b < 16; b++) begin
        if (!stop) begin
          if (b == 0) result_i = v0 + 10'(cv * 341);
          if (b == 6) result_i = ~result_i;
          if (!(cv == 0 && b == 0 && !hi_start)) begin
            sclk = 1'b0;
            din = (b < 8) ? c[7-b] : 1'b0;
          end
          wait_clk(H);
          sclk = 1'b1; rises++;
          wait_clk(H / 2);
          if (b >= 4 && b <= 13) w[13-b] = dout_o;
          if (b == 8) ch = chan_o;
          wait_clk(H - H / 2);
          if (rises == max_rises) stop = 1;
          if (b == 15) begin rxq.push_back(int'(w)); chq.push_back(int'(ch)); end
        end
      end
    end
    cs_n = 1'b1;
    wait_clk(H);
  endtask

  initial begin
    rst_n = 0; cs_n = 1; sclk = 0; din = 0; result_i = 0;
    wait_clk(4);
    rst_n = 1;
    wait_clk(2);
    chk("R1 reset dout_oe_o", int'(dout_oe_o), 0);
    chk("R1 reset pwrdn_o", int'(pwrdn_o), 1);
    chk("R1 reset track_o", int'(track_o), 0);
    chk("R1 reset hold_o", int'(hold_o), 0);
    chk("R1 reset dout_o", int'(dout_o), 0);
    chk("R8 reset chan_o", int'(chan_o), 0);
    cmp_en = 1;

    for (int i = 0; i < 6; i++) begin sclk = ~sclk; din = ~din; wait_clk(H); end
    chk("R1 SCLK ignored while CS high: track_o", int'(track_o), 0);
    chk("R1 SCLK ignored while CS high: dout_oe_o", int'(dout_oe_o), 0);

    // Frame A: SCLK parked low, two slots
    do_frame(2, 8'hFF, 8'hE7, 10'h3FF, 0, 99);
    chk("R9 slots received in frame A", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk("R6 all-ones word shifted out", rxq[0], 'h3FF);
      chk("R5 second word sampled at hold", rxq[1], 'h154);
      chk("R8 first slot after reset uses channel 0", chq[0], 0);
      chk("R7 byte FF selects channel 3", chq[1], 3);
    end

    // Frame B: SCLK parked high, three slots
    do_frame(3, 8'h08, 8'h10, 10'h000, 1, 99);
    chk("R9 slots received in frame B", rxq.size(), 3);
    if (rxq.size() == 3) begin
      chk("R6 all-zero word", rxq[0], 'h000);
      chk("R9 second back-to-back word", rxq[1], 'h155);
      chk("R9 third back-to-back word", rxq[2], 'h2AA);
      chk("R7 byte E7 ignores bits 7:5 and 2:0", chq[0], 0);
      chk("R7 byte 08 selects channel 1", chq[1], 1);
      chk("R7 byte 10 selects channel 2", chq[2], 2);
    end

    // Frame C: pending channel crosses CS-high gap
    do_frame(1, 8'h18, 8'h18, 10'h2C3, 0, 99);
    chk("R9 slots received in frame C", rxq.size(), 1);
    if (rxq.size() == 1) begin
      chk("R8 address carried across CS gap", chq[0], 1);
      chk("R5 late result change not sent", rxq[0], 'h2C3);
    end

    // Frame D: abort after five rising edges
    do_frame(1, 8'h00, 8'h00, 10'h111, 0, 5);
    chk("R11 no complete slot in aborted frame", rxq.size(), 0);
    chk("R11 idle after abort: dout_oe_o", int'(dout_oe_o), 0);
    chk("R11 idle after abort: pwrdn_o", int'(pwrdn_o), 1);

    // Frame E: partial byte must not have changed the pending channel
    do_frame(1, 8'h00, 8'h00, 10'h0F0, 1, 99);
    chk("R9 slots received in frame E", rxq.size(), 1);
    if (rxq.size() == 1) begin
      chk("R11 partial byte left channel 3", chq[0], 3);
      chk("R6 word in frame E", rxq[0], 'h0F0);
    end

    wait_clk(4);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule